// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Path

This block is the transmit side of a byte-oriented serial port. A CPU writes bytes into a holding register. A separate shift register drives the serial data line one bit per shift-clock enable pulse. When the shift register has no work and a byte is waiting, the byte moves across and its first bit appears on the line. A byte written while another is still being shifted waits in the holding register. It is chained in on the edge that sends the last bit of the current byte, so consecutive bytes leave with no idle gap.

The bit order is chosen per write. In MSB-first order the byte is kept as written. In LSB-first order it is stored with its bits mirrored. The shifter always sends from the top bit, and a CPU read of the holding register returns the mirrored image. Start and stop framing, acknowledge, arbitration and addressing belong to the surrounding controller.

Top module: `ser_tx_path`

## Requirements
- R1: After reset the holding register reads 0xFF, the holding-empty flag is 1, busy is 0 and the serial output is 1.
- R2: A CPU write clears the holding-empty flag on the next cycle. With `lsb_first`=0, the holding register then reads back the written byte unchanged.
- R3: A CPU write with `lsb_first`=1 makes the holding register read back the byte with bit i moved to bit 7-i.
- R4: When the shifter is idle and a byte is pending, the byte is loaded one cycle later. At that point holding-empty returns to 1, busy goes to 1 and the first bit is on the serial output.
- R5: Each cycle with `shift_en`=1 while busy advances the output by exactly one bit. Cycles without `shift_en` leave the output unchanged.
- R6: A byte written with `lsb_first`=0 is sent bit 7 first. A byte written with `lsb_first`=1 is sent bit 0 first.
- R7: A byte pending when the eighth bit of the current byte is shifted out is loaded on that same edge. Its first bit appears immediately, with no idle cycle.
- R8: After the eighth pulse with nothing pending, busy falls to 0 and the serial output idles at 1.
- R9: If a CPU write coincides with a transfer into the shifter, the shifter takes the old holding byte. The new byte stays pending: holding-empty stays 0 and the read-back shows the new byte.
- R10: `shift_en` pulses while idle have no effect: the output stays 1, busy stays 0 and holding-empty stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe for the holding register |
| wr_data | input | 8 | CPU write data |
| lsb_first | input | 1 | Bit order for the byte being written: 0 MSB-first, 1 LSB-first |
| rd_data | output | 8 | CPU read-back of the holding register |
| shift_en | input | 1 | Shift-clock enable, one bit per asserted cycle |
| sdo | output | 1 | Serial data output |
| hold_empty | output | 1 | 1 when the holding register has no pending byte |
| busy | output | 1 | 1 while the shift register holds a byte being sent |

## Verification
A CPU write and the transfer of the holding byte into the shifter can happen on the same clock edge. The bench provokes this while the shifter is on the last bit of a byte with another byte already pending: it writes a third byte in the same cycle as the final shift pulse. It then checks four things: the serial line shows the first bit of the previously pending byte at once; holding-empty stays 0; the read-back shows the third byte; and that third byte is later sent in full after the second.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

   // Bit order selected for a byte at write time
   typedef enum logic {
      ORD_MSB_FIRST = 1'b0,
      ORD_LSB_FIRST = 1'b1
   } bit_order_e;

   localparam int unsigned DEF_DATA_W = 8;

endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold
   import ser_tx_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter logic [DATA_W-1:0] RST_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  bit_order_e        order,
   input  logic              take,
   output logic [DATA_W-1:0] hold_q,
   output logic              empty_q
);

   logic [DATA_W-1:0] mirrored;
   logic [DATA_W-1:0] store_val;

   // Bit-reversed copy of the write data
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mirror
      assign mirrored[gi] = wr_data[DATA_W-1-gi];
   end

   assign store_val = (order == ORD_LSB_FIRST) ? mirrored : wr_data;

   // A write in the same cycle as a transfer wins: it stays pending
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= RST_VAL;
         empty_q <= 1'b1;
      end else begin
         if (take) begin
            empty_q <= 1'b1;
         end
         if (wr_en) begin
            hold_q  <= store_val;
            empty_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
   parameter int unsigned DATA_W     = 8,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              pending,
   input  logic [DATA_W-1:0] load_data,
   output logic              take,
   output logic              sdo,
   output logic              active_q
);

   localparam int unsigned CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  left_q;
   logic              last_bit;
   logic              step;

   assign step     = active_q && shift_en;
   assign last_bit = (left_q == ONE_CNT);
   // Load when idle, or on the edge that sends the final bit
   assign take     = pending && (!active_q || (step && last_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         left_q   <= '0;
         active_q <= 1'b0;
      end else if (take) begin
         sh_q     <= load_data;
         left_q   <= FULL_CNT;
         active_q <= 1'b1;
      end else if (step) begin
         sh_q     <= {sh_q[DATA_W-2:0], 1'b0};
         left_q   <= left_q - ONE_CNT;
         if (last_bit) begin
            active_q <= 1'b0;
         end
      end
   end

   assign sdo = active_q ? sh_q[DATA_W-1] : IDLE_LEVEL;

endmodule

// File: rtl/ser_tx_path.sv
module ser_tx_path
   import ser_tx_pkg::*;
#(
   parameter int unsigned DATA_W     = DEF_DATA_W,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lsb_first,
   output logic [DATA_W-1:0] rd_data,
   input  logic              shift_en,
   output logic              sdo,
   output logic              hold_empty,
   output logic              busy
);

   localparam logic [DATA_W-1:0] HOLD_RST = '1;

   if (DATA_W < 2) begin : g_bad_width
      $error("ser_tx_path: DATA_W must be at least 2");
   end

   logic              take;
   logic [DATA_W-1:0] hold_q;
   bit_order_e        order;

   assign order = bit_order_e'(lsb_first);

   ser_tx_hold #(
      .DATA_W  (DATA_W),
      .RST_VAL (HOLD_RST)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .order   (order),
      .take    (take),
      .hold_q  (hold_q),
      .empty_q (hold_empty)
   );

   ser_tx_shifter #(
      .DATA_W     (DATA_W),
      .IDLE_LEVEL (IDLE_LEVEL)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (shift_en),
      .pending   (!hold_empty),
      .load_data (hold_q),
      .take      (take),
      .sdo       (sdo),
      .active_q  (busy)
   );

   assign rd_data = hold_q;

endmodule

// File: rtl/ser_tx_path_chk.sv
module ser_tx_path_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              lsb_first,
   input logic [DATA_W-1:0] rd_data,
   input logic              shift_en,
   input logic              sdo,
   input logic              hold_empty,
   input logic              busy
);

   logic [DATA_W-1:0] wr_rev;
   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         wr_rev[i] = wr_data[DATA_W-1-i];
      end
   end

   // R2
   wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !hold_empty);

   // R3
   lsb_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lsb_first) |=> (rd_data == $past(wr_rev)));

   // R4
   idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !hold_empty) |=> (busy && hold_empty == !$past(wr_en)));

   // R5
   hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !shift_en) |=> (busy && $stable(sdo)));

   // R8
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sdo == IDLE_LEVEL));

   // R10
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && hold_empty && !wr_en) |=> (!busy && hold_empty));

endmodule

bind ser_tx_path ser_tx_path_chk #(
   .DATA_W     (DATA_W),
   .IDLE_LEVEL (IDLE_LEVEL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .lsb_first  (lsb_first),
   .rd_data    (rd_data),
   .shift_en   (shift_en),
   .sdo        (sdo),
   .hold_empty (hold_empty),
   .busy       (busy)
);

// File: tb/ser_tx_path_tb.sv
module ser_tx_path_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       lsb_first = 1'b0;
   logic [7:0] rd_data;
   logic       shift_en = 1'b0;
   logic       sdo;
   logic       hold_empty;
   logic       busy;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ser_tx_path u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .lsb_first  (lsb_first),
      .rd_data    (rd_data),
      .shift_en   (shift_en),
      .sdo        (sdo),
      .hold_empty (hold_empty),
      .busy       (busy)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic pulse();
      shift_en = 1'b1;
      step();
      shift_en = 1'b0;
   endtask

   task automatic cpu_write(input logic [7:0] d, input logic lsb);
      wr_en = 1'b1; wr_data = d; lsb_first = lsb;
      step();
      wr_en = 1'b0;
   endtask

   // Check every bit of byte d on sdo, pulsing after each
   task automatic send_check(input string req, input logic [7:0] d, input logic lsb);
      for (int i = 0; i < 8; i++) begin
         check(req, {7'd0, sdo}, {7'd0, lsb ? d[i] : d[7-i]});
         pulse();
      end
   endtask

   task automatic t_reset();
      check("R1 rd_data", rd_data, 8'hFF);
      check("R1 hold_empty", {7'd0, hold_empty}, 8'd1);
      check("R1 busy", {7'd0, busy}, 8'd0);
      check("R1 sdo", {7'd0, sdo}, 8'd1);
   endtask

   task automatic t_idle_shift();
      for (int i = 0; i < 3; i++) pulse();
      check("R10 sdo", {7'd0, sdo}, 8'd1);
      check("R10 busy", {7'd0, busy}, 8'd0);
      check("R10 hold_empty", {7'd0, hold_empty}, 8'd1);
   endtask

   task automatic t_msb();
      cpu_write(8'hA5, 1'b0);
      check("R2 hold_empty", {7'd0, hold_empty}, 8'd0);
      check("R2 rd_data", rd_data, 8'hA5);
      step();
      check("R4 hold_empty", {7'd0, hold_empty}, 8'd1);
      check("R4 busy", {7'd0, busy}, 8'd1);
      for (int i = 0; i < 8; i++) begin
         check("R6 msb bit", {7'd0, sdo}, {7'd0, 8'hA5 >> (7 - i) & 8'h01});
         if (i == 3) begin
            step(); step();
            check("R5 hold without pulse", {7'd0, sdo}, {7'd0, 8'hA5 >> 4 & 8'h01});
         end
         pulse();
      end
      check("R8 busy", {7'd0, busy}, 8'd0);
      check("R8 sdo", {7'd0, sdo}, 8'd1);
   endtask

   task automatic t_lsb();
      cpu_write(8'h1E, 1'b1);
      check("R3 rd_data", rd_data, 8'h78);
      step();
      send_check("R6 lsb bit", 8'h1E, 1'b1);
      check("R8 busy after lsb", {7'd0, busy}, 8'd0);
   endtask

   task automatic t_chain();
      cpu_write(8'hC3, 1'b0);
      step();
      for (int i = 0; i < 7; i++) begin
         check("R5 first byte bit", {7'd0, sdo}, {7'd0, 8'hC3 >> (7 - i) & 8'h01});
         if (i == 3) cpu_write(8'h5A, 1'b0);
         pulse();
      end
      check("R7 pending", {7'd0, hold_empty}, 8'd0);
      check("R5 last bit", {7'd0, sdo}, {7'd0, 8'hC3 & 8'h01});
      // Last pulse together with a new write
      shift_en = 1'b1; wr_en = 1'b1; wr_data = 8'h96; lsb_first = 1'b0;
      step();
      shift_en = 1'b0; wr_en = 1'b0;
      check("R7 busy no gap", {7'd0, busy}, 8'd1);
      check("R9 hold_empty", {7'd0, hold_empty}, 8'd0);
      check("R9 rd_data", rd_data, 8'h96);
      send_check("R7 chained byte", 8'h5A, 1'b0);
      send_check("R9 third byte", 8'h96, 1'b0);
      check("R8 busy after chain", {7'd0, busy}, 8'd0);
      check("R8 sdo after chain", {7'd0, sdo}, 8'd1);
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_idle_shift();
      t_msb();
      t_lsb();
      t_chain();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule